// File: doc/BRIEF.md
# Round-Robin Read Cache with Line Locking

This block is a read-only cache that sits between a requester and a slower memory. Every set holds 32 ways, and all 32 tags of the addressed set are compared in parallel. On a hit the requested word comes back one cycle after the request is accepted. On a miss the cache asks the memory for the whole line and takes the words one at a time into a staging buffer. Once the line is complete it is written into the array, and the requested word is returned, marked as a miss.

Each set has its own replacement pointer that walks the ways in turn. A request can carry a lock flag. A lock that hits pins the line at once. A lock that misses pins the line in the same cycle it is allocated. A pinned line is never chosen as a victim: the victim search starts at the pointer and passes over pinned ways. If every way of a set is pinned, a miss is still answered from the staging buffer, but no line is allocated. Addresses are word addresses. Capacity, way count, line size and word width are parameters, and the defaults give 32 KB with 32-byte lines.

Top module: `rrcache`

## Requirements
- R1: After reset no line is valid or locked and every pointer is at way 0: reqReady is 1, fillReq and rspValid are 0, and the first lookup of any address misses.
- R2: A request accepted (reqValid and reqReady at a clock edge) that matches a valid line drives rspValid=1 and rspHit=1 after that same edge, with the addressed word on rspData. reqReady stays 1, so a new request can be accepted on every cycle.
- R3: A request that misses raises fillReq after its accepting edge. fillAddr is the word address of the line's first word (word bits zero). reqReady stays 0 until the miss has been answered.
- R4: Fill words arrive on fillData while fillValid is 1, word 0 first and one per accepted cycle, with idle cycles allowed in between. rspValid stays 0 in the cycle after the last word is taken. It rises at the following edge with rspHit=0 and the requested word taken from the staged line.
- R5: fillValid has no effect while fillReq is 0: no response appears and stored lines are unchanged.
- R6: Each set allocates in round-robin order starting at way 0. The pointer then moves to the way after the victim, so once a set is full its oldest allocated line is evicted first.
- R7: Each set has its own pointer. Misses in one set never change which line is evicted in another set.
- R8: A request with reqLock=1 that hits returns a normal hit and pins the line. A pinned line stays resident through any number of later misses in its set.
- R9: A request with reqLock=1 that misses fills a line and pins it in the same cycle the line is written.
- R10: The victim is the first unpinned way at or after the set pointer, in ascending order with wrap-around. Pinned ways are skipped.
- R11: When all ways of a set are pinned, a miss still returns the fill word with rspHit=0, but no line is allocated. A repeat of the same address misses again, and every pinned line still hits.
- R12: The word address splits, from the least significant end, into log2(words per line) word bits, then log2(SETS) set bits, then the tag. SETS = CAP_BYTES / (LINE_BYTES × WAYS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Word address of the request |
| reqLock | input | 1 | Pin the addressed line |
| reqReady | output | 1 | Cache can accept a request |
| rspValid | output | 1 | Response word valid |
| rspHit | output | 1 | Response came from the array (1) or from a fill (0) |
| rspData | output | WORD_W | Response word |
| fillReq | output | 1 | Line fetch outstanding |
| fillAddr | output | ADDR_W | Word address of the first word of the line being fetched |
| fillValid | input | 1 | Fill word present |
| fillData | input | WORD_W | Fill word |

## Verification
A lock request that misses makes allocation and pinning fall in the same commit cycle. The victim has to be chosen from the lock state as it was before that cycle, and the new pin has to take effect from the next miss onward. The bench provokes this by filling a whole set with locking misses and then issuing a fresh miss to that set. It judges the result at the ports: the fresh miss is answered from the fill, it misses again when repeated, and all 32 pinned lines still hit. Separately, two pins placed among a full set show that later victims pass over them in pointer order.

// File: rtl/rrcache_pkg.sv
package rrcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_COMMIT = 2'd2
  } ctlState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic capture;  // request accepted this cycle
    logic beat;     // one fill word taken into the staging buffer
    logic commit;   // staged line written (if a victim exists) and answered
  } ctlStrobe_t;

endpackage

// File: rtl/rrcache_ctrl.sv
module rrcache_ctrl
  import rrcache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       fillValid,
  input  logic       lookupHit,
  input  logic       lastBeat,
  output logic       reqReady,
  output logic       fillReq,
  output ctlStrobe_t stb
);

  ctlState_t state, stateNxt;

  assign reqReady = (state == ST_IDLE);
  assign fillReq  = (state == ST_FILL);

  always_comb begin
    stb      = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.capture = 1'b1;
          if (!lookupHit) stateNxt = ST_FILL;
        end
      end
      ST_FILL: begin
        if (fillValid) begin
          stb.beat = 1'b1;
          if (lastBeat) stateNxt = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        stb.commit = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // a miss on an accepted request opens a line fetch at the next edge (R3)
  p_miss_opens_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !lookupHit |=> fillReq && !reqReady);

  // the last fill word closes the fetch and still blocks new requests (R4)
  p_last_beat_closes_r4: assert property (@(posedge clk) disable iff (!rstN)
    fillReq && fillValid && lastBeat |=> !fillReq && !reqReady);

endmodule

// File: rtl/rrcache_dp.sv
module rrcache_dp
  import rrcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 32,
  parameter int CAP_BYTES  = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqLock,
  input  logic [WORD_W-1:0] fillData,
  output logic              lookupHit,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] fillAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WORD_W-1:0] rspData
);

  // geometry (WAYS, SETS and words per line are powers of two, SETS >= 2, WPL >= 2)
  localparam int LINES  = CAP_BYTES / LINE_BYTES;
  localparam int SETS   = LINES / WAYS;
  localparam int WPL    = (LINE_BYTES * 8) / WORD_W;
  localparam int OFF_W  = $clog2(WPL);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int LIDX_W = SET_W + WAY_W;
  localparam int LINE_W = WPL * WORD_W;

  function automatic logic [LIDX_W-1:0] lineIdx(input logic [SET_W-1:0] s,
                                                input logic [WAY_W-1:0] w);
    return {s, w};
  endfunction

  // storage
  logic [LINES-1:0]  validQ, lockQ;
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [LINE_W-1:0] dataMem [LINES];
  logic [WAY_W-1:0]  ptrQ    [SETS];

  // live lookup on the incoming address
  logic [TAG_W-1:0] lkTag;
  logic [SET_W-1:0] lkSet;
  logic [OFF_W-1:0] lkWord;
  logic [WAY_W-1:0] hitWay;
  logic [LINE_W-1:0] hitLine;
  logic [WORD_W-1:0] hitWord;

  assign lkTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign lkSet  = reqAddr[OFF_W +: SET_W];
  assign lkWord = reqAddr[OFF_W-1:0];

  always_comb begin
    lookupHit = 1'b0;
    hitWay    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (validQ[lineIdx(lkSet, WAY_W'(w))] && tagMem[lineIdx(lkSet, WAY_W'(w))] == lkTag) begin
        lookupHit = 1'b1;
        hitWay    = WAY_W'(w);
      end
    end
  end

  assign hitLine = dataMem[lineIdx(lkSet, hitWay)];
  assign hitWord = hitLine[lkWord*WORD_W +: WORD_W];

  // held miss request
  logic [ADDR_W-1:0] curAddr;
  logic              curLock;
  logic [TAG_W-1:0]  curTag;
  logic [SET_W-1:0]  curSet;
  logic [OFF_W-1:0]  curWord;

  assign curTag   = curAddr[ADDR_W-1 -: TAG_W];
  assign curSet   = curAddr[OFF_W +: SET_W];
  assign curWord  = curAddr[OFF_W-1:0];
  assign fillAddr = {curAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      curLock <= 1'b0;
    end else if (stb.capture) begin
      curAddr <= reqAddr;
      curLock <= reqLock;
    end
  end

  // victim search: first unpinned way from the set pointer upward, wrapping
  logic             vicFound;
  logic [WAY_W-1:0] vicWay, cand;
  logic [LIDX_W-1:0] vIdx;

  always_comb begin
    vicFound = 1'b0;
    vicWay   = ptrQ[curSet];
    cand     = '0;
    for (int i = 0; i < WAYS; i++) begin
      cand = ptrQ[curSet] + WAY_W'(i);
      if (!vicFound && !lockQ[lineIdx(curSet, cand)]) begin
        vicFound = 1'b1;
        vicWay   = cand;
      end
    end
  end

  assign vIdx = lineIdx(curSet, vicWay);

  // fill staging buffer
  logic [WORD_W-1:0] fillBuf [WPL];
  logic [OFF_W-1:0]  beatCnt;
  logic [LINE_W-1:0] fillLine;

  assign lastBeat = (beatCnt == OFF_W'(WPL - 1));

  for (genvar g = 0; g < WPL; g++) begin : g_line
    assign fillLine[g*WORD_W +: WORD_W] = fillBuf[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) beatCnt <= '0;
    else if (stb.capture) beatCnt <= '0;
    else if (stb.beat) beatCnt <= beatCnt + OFF_W'(1);
  end

  always_ff @(posedge clk) begin
    if (stb.beat) fillBuf[beatCnt] <= fillData;
  end

  // state bits and pointers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      lockQ  <= '0;
      for (int s = 0; s < SETS; s++) ptrQ[s] <= '0;
    end else begin
      if (stb.capture && lookupHit && reqLock) lockQ[lineIdx(lkSet, hitWay)] <= 1'b1;
      if (stb.commit && vicFound) begin
        validQ[vIdx] <= 1'b1;
        lockQ[vIdx]  <= curLock;
        ptrQ[curSet] <= vicWay + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.commit && vicFound) begin
      tagMem[vIdx]  <= curTag;
      dataMem[vIdx] <= fillLine;
    end
  end

  // response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= (stb.capture && lookupHit) || stb.commit;
      if (stb.capture && lookupHit) begin
        rspHit  <= 1'b1;
        rspData <= hitWord;
      end else if (stb.commit) begin
        rspHit  <= 1'b0;
        rspData <= fillBuf[curWord];
      end
    end
  end

  // an accepted hit is answered at the next edge (R2)
  p_hit_answer_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && lookupHit |=> rspValid && rspHit);

  // a committed line never lands on a pinned way (R10)
  p_victim_unpinned_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit && vicFound |-> !lockQ[vIdx]);

  // pins are never released while out of reset (R8)
  p_pins_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $countones(lockQ) >= $past($countones(lockQ)));

  // a fully pinned set keeps its pointer and valid bits (R11)
  p_full_pin_no_alloc_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit && !vicFound |=> $stable(ptrQ[curSet]) && $stable(validQ));

endmodule

// File: rtl/rrcache.sv
module rrcache
  import rrcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 32,
  parameter int CAP_BYTES  = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqLock,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WORD_W-1:0] rspData,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillValid,
  input  logic [WORD_W-1:0] fillData
);

  ctlStrobe_t stb;
  logic       lookupHit;
  logic       lastBeat;

  rrcache_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .fillValid (fillValid),
    .lookupHit (lookupHit),
    .lastBeat  (lastBeat),
    .reqReady  (reqReady),
    .fillReq   (fillReq),
    .stb       (stb)
  );

  rrcache_dp #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_BYTES (LINE_BYTES),
    .WAYS       (WAYS),
    .CAP_BYTES  (CAP_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqLock   (reqLock),
    .fillData  (fillData),
    .lookupHit (lookupHit),
    .lastBeat  (lastBeat),
    .fillAddr  (fillAddr),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspData   (rspData)
  );

endmodule

// File: tb/sim_rrcache.sv
`timescale 1ns/1ps
module sim_rrcache;

  // small configuration: 32 ways, 8-byte lines (2 words), 2 sets
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqLock = 1'b0;
  logic          reqReady, rspValid, rspHit, fillReq;
  logic [DW-1:0] rspData;
  logic [AW-1:0] fillAddr;
  logic          fillValid = 1'b0;
  logic [DW-1:0] fillData = '0;

  int total = 0;
  int bad = 0;
  bit gapToggle = 1'b0;

  always #2 clk = ~clk;

  rrcache #(.ADDR_W(AW), .WORD_W(DW), .LINE_BYTES(8), .WAYS(32), .CAP_BYTES(512)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqLock(reqLock),
    .reqReady(reqReady), .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData),
    .fillReq(fillReq), .fillAddr(fillAddr), .fillValid(fillValid), .fillData(fillData)
  );

  // word address: tag above bit 2, set at bit 1, word at bit 0 (R12)
  function automatic logic [AW-1:0] mk(input int tag, input int set, input int w);
    return AW'((tag << 2) | (set << 1) | w);
  endfunction

  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] lineAddr, input int w);
    return {lineAddr ^ 16'h5AA5, 16'(16'h1000 + w)};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // one request, fill served if the cache asks for it
  task automatic access(input int tag, input int set, input int w, input bit lock,
                        input bit expHit, input string rq);
    logic [AW-1:0] a, la;
    logic [DW-1:0] expData;
    bit gotHit;
    int waitN;
    a = mk(tag, set, w);
    la = mk(tag, set, 0);
    expData = memWord(la, w);
    gotHit = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqLock = lock;
    waitN = 0;
    while (!reqReady && waitN < 50) begin @(negedge clk); waitN++; end
    @(negedge clk);
    reqValid = 1'b0; reqLock = 1'b0;
    if (rspValid) begin
      gotHit = rspHit;
      chk(rspHit == 1'b1, rq, "hit flag on immediate answer", DW'(rspHit), 32'd1);
      chk(rspData == expData, rq, "hit data", rspData, expData);
    end else if (fillReq) begin
      chk(fillAddr == la, "R3", "fill address", DW'(fillAddr), DW'(la));
      chk(reqReady == 1'b0, "R3", "ready low during fetch", DW'(reqReady), 32'd0);
      for (int b = 0; b < 2; b++) begin
        gapToggle = ~gapToggle;
        if (gapToggle) begin fillValid = 1'b0; @(negedge clk); end
        fillValid = 1'b1; fillData = memWord(la, b);
        @(negedge clk);
      end
      fillValid = 1'b0; fillData = '0;
      chk(rspValid == 1'b0, "R4", "no answer in commit cycle", DW'(rspValid), 32'd0);
      @(negedge clk);
      chk(rspValid == 1'b1 && rspHit == 1'b0, "R4", "miss answer valid/hit",
          DW'({rspValid, rspHit}), 32'd2);
      chk(rspData == expData, "R4", "miss data", rspData, expData);
      gotHit = 1'b0;
    end else begin
      chk(1'b0, rq, "no answer and no fetch", 32'd0, 32'd1);
    end
    chk(gotHit == expHit, rq, $sformatf("hit/miss of tag %0d set %0d", tag, set),
        DW'(gotHit), DW'(expHit));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state at the ports
    chk(reqReady == 1'b1, "R1", "ready after reset", DW'(reqReady), 32'd1);
    chk(fillReq == 1'b0, "R1", "no fetch after reset", DW'(fillReq), 32'd0);
    chk(rspValid == 1'b0, "R1", "no answer after reset", DW'(rspValid), 32'd0);

    // fill set 0 in way order; first lookup misses (R1, R6)
    for (int t = 0; t < 32; t++) access(100 + t, 0, t % 2, 0, 0, (t == 0) ? "R1" : "R6");
    for (int t = 0; t < 4; t++) access(200 + t, 1, 0, 0, 0, "R12");
    for (int t = 0; t < 32; t++)
      for (int w = 0; w < 2; w++) access(100 + t, 0, w, 0, 1, "R2");

    // R2 back-to-back hits
    @(negedge clk);
    reqValid = 1'b1; reqAddr = mk(110, 0, 1);
    @(negedge clk);
    chk(rspValid && rspHit, "R2", "first of pair answered", DW'({rspValid, rspHit}), 32'd3);
    chk(rspData == memWord(mk(110, 0, 0), 1), "R2", "first of pair data", rspData, memWord(mk(110, 0, 0), 1));
    chk(reqReady == 1'b1, "R2", "ready stays high", DW'(reqReady), 32'd1);
    reqAddr = mk(201, 1, 0);
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid && rspHit, "R2", "second of pair answered", DW'({rspValid, rspHit}), 32'd3);
    chk(rspData == memWord(mk(201, 1, 0), 0), "R2", "second of pair data", rspData, memWord(mk(201, 1, 0), 0));

    // R5 stray fill words while idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      fillValid = 1'b1; fillData = 32'hDEAD_0000 + DW'(k);
    end
    @(negedge clk);
    fillValid = 1'b0; fillData = '0;
    chk(rspValid == 1'b0 && fillReq == 1'b0, "R5", "stray words give no answer",
        DW'({rspValid, fillReq}), 32'd0);
    access(105, 0, 1, 0, 1, "R5");
    access(100, 0, 0, 0, 1, "R5");

    // R6 eviction order: way 0 (tag 100) goes first
    access(132, 0, 0, 0, 0, "R6");
    for (int t = 1; t < 32; t++) access(100 + t, 0, 0, 0, 1, "R6");
    for (int t = 0; t < 4; t++) access(200 + t, 1, 1, 0, 1, "R7");
    access(100, 0, 1, 0, 0, "R6");
    access(101, 0, 0, 0, 0, "R6");
    access(132, 0, 1, 0, 1, "R6");
    // R7 set 1 pointer independent: next victim there is way 4
    access(204, 1, 0, 0, 0, "R7");
    for (int t = 0; t < 5; t++) access(200 + t, 1, 0, 0, 1, "R7");

    // locking: pins by hit, victims skip them
    doReset();
    for (int t = 0; t < 32; t++) access(300 + t, 0, t % 2, 0, 0, (t == 0) ? "R1" : "R6");
    access(300, 0, 0, 1, 1, "R8");
    access(302, 0, 1, 1, 1, "R8");
    access(400, 0, 0, 0, 0, "R10");
    access(401, 0, 1, 0, 0, "R10");
    access(300, 0, 1, 0, 1, "R10");
    access(302, 0, 0, 0, 1, "R10");
    for (int t = 4; t < 32; t++) access(300 + t, 0, 0, 0, 1, "R10");
    access(400, 0, 1, 0, 1, "R10");
    access(401, 0, 0, 0, 1, "R10");
    access(301, 0, 0, 0, 0, "R10");
    access(303, 0, 0, 0, 0, "R10");
    access(304, 0, 0, 0, 0, "R10");
    access(300, 0, 0, 0, 1, "R8");
    access(302, 0, 1, 0, 1, "R8");

    // R9 pin on miss, then R11 fully pinned set
    for (int t = 0; t < 32; t++) access(500 + t, 1, t % 2, 1, 0, "R9");
    access(600, 1, 0, 0, 0, "R11");
    access(600, 1, 1, 0, 0, "R11");
    access(601, 1, 1, 1, 0, "R11");
    for (int t = 0; t < 32; t++) access(500 + t, 1, 1, 0, 1, "R9");
    access(700, 0, 0, 0, 0, "R11");
    access(700, 0, 1, 0, 1, "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule